// File: doc/BRIEF.md
# Bus Interval Boundary Timekeeper

This block holds a device's local view of where the host's bus intervals begin. A fine counter advances once per timestamp-clock strobe and runs from 0 to 7499. When it rolls over, a coarse 14-bit interval number advances, and a one-cycle boundary pulse marks the rollover.

When an isochronous timestamp packet arrives, the upstream parser presents three fields: an interval number, the time elapsed since the previous boundary, and a correction that hubs have accumulated along the path. The block resynchronises both counters from these fields. It compensates for the measured link delay and the configured isochronous delay. Packets whose elapsed-time field is out of range are discarded.

Packet parsing, CRC checking and the delay measurement itself are done by neighbouring blocks.

Top module: `bus_interval_timer`

## Requirements
- R1: On a cycle with `tick_i` high and no accepted packet, `delta_o` increases by one. `delta_o` never leaves the range 0 to 7499.
- R2: On a tick while `delta_o` is 7499 with no accepted packet, `delta_o` becomes 0 and `interval_o` increases by one modulo 16384, so 16383 becomes 0.
- R3: `boundary_o` is high for exactly the one cycle that follows a rollover edge from R2. In that cycle `delta_o` reads 0. At no other time is it high.
- R4: A packet is accepted when `pkt_valid_i` is high and `pkt_delta_i` is at most 7499. On acceptance, `delta_o` loads (isoch_delay + link_delay + pkt_delta − pkt_corr) reduced into 0..7499, and a negative sum wraps upward.
- R5: On acceptance, `interval_o` loads pkt_interval + floor((link_delay + pkt_delta) / 7500), taken modulo 16384.
- R6: A packet with `pkt_delta_i` of 7500 or more has no effect. The counters and the pulse behave exactly as if `pkt_valid_i` were low.
- R7: When a packet is accepted in the same cycle as a tick, the load wins. The tick is dropped and no boundary pulse follows.
- R8: With neither a tick nor an accepted packet, both counters hold and `boundary_o` stays low.
- R9: An active-low `rst_ni` clears `delta_o`, `interval_o` and `boundary_o` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per timestamp-clock period |
| pkt_valid_i | input | 1 | Timestamp packet fields are valid this cycle |
| pkt_interval_i | input | 14 | Interval number carried by the packet |
| pkt_delta_i | input | 13 | Elapsed time since the previous boundary, from the packet |
| pkt_corr_i | input | 16 | Accumulated hub correction, from the packet |
| link_delay_i | input | 16 | Measured upstream link delay, in timestamp-clock units |
| isoch_delay_i | input | 16 | Configured isochronous delay, in timestamp-clock units |
| delta_o | output | 13 | Fine counter, 0 to 7499 |
| interval_o | output | 14 | Coarse interval counter |
| boundary_o | output | 1 | One-cycle pulse after each fine-counter rollover |

## Verification
The hardest conditions to reach are the two rare rollovers: the coarse counter passing from 16383 to 0, and a tick that collides with an accepted load while the fine counter sits at 7499. Free-running ticks from reset would take over 120 million strobes to reach the coarse wrap. The stimulus therefore uses the load path with chosen isochronous delay and interval fields to place both counters one step before each rollover, then ticks across it. A swept grid of delay, correction and elapsed-time values drives the negative and multi-interval cases of the reload arithmetic.

// File: rtl/bit_pkg.sv
package bit_pkg;

    // Which update a counter pair applies on the coming edge.
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_ADVANCE = 2'd1,
        UPD_RELOAD  = 2'd2
    } upd_e;

endpackage

// File: rtl/bit_resync.sv
// Combinational reload arithmetic for a received timestamp packet.
module bit_resync #(
    parameter int DELTA_W   = 13,
    parameter int DELTA_MOD = 7500,
    parameter int BI_W      = 14,
    parameter int CORR_W    = 16,
    parameter int LINK_W    = 16,
    parameter int ISO_W     = 16
) (
    input  logic [BI_W-1:0]    pkt_interval_i,
    input  logic [DELTA_W-1:0] pkt_delta_i,
    input  logic [CORR_W-1:0]  pkt_corr_i,
    input  logic [LINK_W-1:0]  link_delay_i,
    input  logic [ISO_W-1:0]   isoch_delay_i,
    output logic               accept_o,
    output logic [DELTA_W-1:0] load_delta_o,
    output logic [BI_W-1:0]    load_interval_o
);

    localparam int ADD_W  = (ISO_W > LINK_W) ? ISO_W : LINK_W;
    localparam int POS_W  = ADD_W + 2;
    localparam int SUM_W  = ((POS_W > CORR_W) ? POS_W : CORR_W) + 2;
    localparam int QIN_W  = ((LINK_W > DELTA_W) ? LINK_W : DELTA_W) + 1;
    localparam logic [DELTA_W-1:0]     DELTA_TOP = DELTA_W'(DELTA_MOD - 1);
    localparam logic signed [SUM_W-1:0] MOD_S    = SUM_W'(DELTA_MOD);
    localparam logic [QIN_W-1:0]        MOD_Q    = QIN_W'(DELTA_MOD);

    typedef struct packed {
        logic [SUM_W-1:0] raw_sum;
        logic [QIN_W-1:0] carry_in;
    } calc_t;

    calc_t                    calc;
    logic signed [SUM_W-1:0]  sum_s;
    logic signed [SUM_W-1:0]  rem_s;
    logic [QIN_W-1:0]         quot;

    always_comb begin
        calc          = '0;
        calc.raw_sum  = SUM_W'(isoch_delay_i) + SUM_W'(link_delay_i)
                      + SUM_W'(pkt_delta_i) - SUM_W'(pkt_corr_i);
        calc.carry_in = QIN_W'(link_delay_i) + QIN_W'(pkt_delta_i);

        sum_s = $signed(calc.raw_sum);
        rem_s = sum_s % MOD_S;
        if (rem_s[SUM_W-1]) begin
            rem_s = rem_s + MOD_S;
        end
        quot = calc.carry_in / MOD_Q;

        accept_o        = (pkt_delta_i <= DELTA_TOP);
        load_delta_o    = DELTA_W'($unsigned(rem_s));
        load_interval_o = pkt_interval_i + BI_W'(quot);
    end

endmodule

// File: rtl/bit_delta_ctr.sv
// Fine counter, modulo DELTA_MOD, with a combinational rollover flag.
module bit_delta_ctr
    import bit_pkg::*;
#(
    parameter int DELTA_W   = 13,
    parameter int DELTA_MOD = 7500
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  upd_e               upd_i,
    input  logic [DELTA_W-1:0] load_i,
    output logic [DELTA_W-1:0] count_o,
    output logic               wrap_o
);

    localparam logic [DELTA_W-1:0] TOP = DELTA_W'(DELTA_MOD - 1);

    typedef struct packed {
        logic [DELTA_W-1:0] cnt;
    } dstate_t;

    dstate_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        unique case (upd_i)
            UPD_RELOAD: st_d.cnt = load_i;
            UPD_ADVANCE: begin
                if (st_q.cnt == TOP) begin
                    st_d.cnt = '0;
                    wrap_o   = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/bit_interval_ctr.sv
// Coarse counter, modulo 2**BI_W, stepped by the fine counter's rollover.
module bit_interval_ctr
    import bit_pkg::*;
#(
    parameter int BI_W = 14
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  upd_e            upd_i,
    input  logic            step_i,
    input  logic [BI_W-1:0] load_i,
    output logic [BI_W-1:0] count_o
);

    typedef struct packed {
        logic [BI_W-1:0] cnt;
    } istate_t;

    istate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i == UPD_RELOAD) begin
            st_d.cnt = load_i;
        end else if (upd_i == UPD_ADVANCE && step_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

endmodule

// File: rtl/bus_interval_timer.sv
module bus_interval_timer
    import bit_pkg::*;
#(
    parameter int DELTA_W   = 13,
    parameter int DELTA_MOD = 7500,
    parameter int BI_W      = 14,
    parameter int CORR_W    = 16,
    parameter int LINK_W    = 16,
    parameter int ISO_W     = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               pkt_valid_i,
    input  logic [BI_W-1:0]    pkt_interval_i,
    input  logic [DELTA_W-1:0] pkt_delta_i,
    input  logic [CORR_W-1:0]  pkt_corr_i,
    input  logic [LINK_W-1:0]  link_delay_i,
    input  logic [ISO_W-1:0]   isoch_delay_i,
    output logic [DELTA_W-1:0] delta_o,
    output logic [BI_W-1:0]    interval_o,
    output logic               boundary_o
);

    typedef struct packed {
        logic pulse;
    } pstate_t;

    logic               accept;
    logic [DELTA_W-1:0] load_delta;
    logic [BI_W-1:0]    load_interval;
    logic               wrap;
    upd_e               upd;
    pstate_t            ps_d, ps_q;

    bit_resync #(
        .DELTA_W(DELTA_W), .DELTA_MOD(DELTA_MOD), .BI_W(BI_W),
        .CORR_W(CORR_W), .LINK_W(LINK_W), .ISO_W(ISO_W)
    ) u_resync (
        .pkt_interval_i (pkt_interval_i),
        .pkt_delta_i    (pkt_delta_i),
        .pkt_corr_i     (pkt_corr_i),
        .link_delay_i   (link_delay_i),
        .isoch_delay_i  (isoch_delay_i),
        .accept_o       (accept),
        .load_delta_o   (load_delta),
        .load_interval_o(load_interval)
    );

    // Reload outranks the tick; a rejected packet is as if absent.
    always_comb begin
        if (pkt_valid_i && accept) begin
            upd = UPD_RELOAD;
        end else if (tick_i) begin
            upd = UPD_ADVANCE;
        end else begin
            upd = UPD_HOLD;
        end
    end

    bit_delta_ctr #(
        .DELTA_W(DELTA_W), .DELTA_MOD(DELTA_MOD)
    ) u_delta (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (upd),
        .load_i (load_delta),
        .count_o(delta_o),
        .wrap_o (wrap)
    );

    bit_interval_ctr #(
        .BI_W(BI_W)
    ) u_interval (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .upd_i  (upd),
        .step_i (wrap),
        .load_i (load_interval),
        .count_o(interval_o)
    );

    always_comb begin
        ps_d       = ps_q;
        ps_d.pulse = wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign boundary_o = ps_q.pulse;

endmodule

// File: rtl/bit_checker.sv
module bit_checker #(
    parameter int DELTA_W   = 13,
    parameter int DELTA_MOD = 7500,
    parameter int BI_W      = 14
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               tick_i,
    input logic               pkt_valid_i,
    input logic [DELTA_W-1:0] pkt_delta_i,
    input logic [DELTA_W-1:0] delta_o,
    input logic [BI_W-1:0]    interval_o,
    input logic               boundary_o
);

    localparam logic [DELTA_W-1:0] TOP = DELTA_W'(DELTA_MOD - 1);

    logic acc;
    assign acc = pkt_valid_i && (pkt_delta_i <= TOP);

    p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        delta_o <= TOP);

    p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !acc && delta_o != TOP) |=>
        (delta_o == DELTA_W'($past(delta_o) + 1'b1)) && $stable(interval_o));

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !acc && delta_o == TOP) |=>
        (delta_o == '0) && (interval_o == BI_W'($past(interval_o) + 1'b1)));

    p_pulse_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary_o |-> (delta_o == '0));

    p_load_no_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> !boundary_o);

    // Also covers a rejected packet without a tick (R6).
    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !acc) |=>
        $stable(delta_o) && $stable(interval_o) && !boundary_o);

endmodule

bind bus_interval_timer bit_checker #(
    .DELTA_W(DELTA_W), .DELTA_MOD(DELTA_MOD), .BI_W(BI_W)
) u_bit_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pkt_valid_i(pkt_valid_i),
    .pkt_delta_i(pkt_delta_i),
    .delta_o    (delta_o),
    .interval_o (interval_o),
    .boundary_o (boundary_o)
);

// File: tb/bus_interval_timer_bench.sv
module bus_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pv = 1'b0;
    logic [13:0] pbi = '0;
    logic [12:0] pd = '0;
    logic [15:0] pc = '0;
    logic [15:0] ld = '0;
    logic [15:0] iso = '0;
    logic [12:0] delta_o;
    logic [13:0] interval_o;
    logic        boundary_o;

    int checks = 0;
    int errors = 0;
    int exp_d = 0;
    int exp_b = 0;
    int exp_p = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_interval_timer u_bus_interval_timer (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pkt_valid_i(pv),
        .pkt_interval_i(pbi), .pkt_delta_i(pd), .pkt_corr_i(pc),
        .link_delay_i(ld), .isoch_delay_i(iso),
        .delta_o(delta_o), .interval_o(interval_o), .boundary_o(boundary_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called just after a falling edge; drives one cycle, checks at the next falling edge.
    task automatic cyc(input bit t, input bit v, input int fbi, input int fd,
                       input int fc, input int fl, input int fi);
        int    s;
        int    m;
        string tg;
        string tgb;
        tick = t; pv = v;
        pbi = 14'(fbi); pd = 13'(fd); pc = 16'(fc); ld = 16'(fl); iso = 16'(fi);
        if (v && fd < 7500) begin
            s = fi + fl + fd - fc;
            m = s % 7500;
            if (m < 0) m += 7500;
            exp_d = m;
            exp_b = (fbi + (fl + fd) / 7500) % 16384;
            exp_p = 0;
            tg  = t ? "R7" : "R4";
            tgb = t ? "R7" : "R5";
        end else if (t) begin
            if (exp_d == 7499) begin
                exp_d = 0;
                exp_b = (exp_b + 1) % 16384;
                exp_p = 1;
                tg = "R2";
            end else begin
                exp_d = exp_d + 1;
                exp_p = 0;
                tg = v ? "R6" : "R1";
            end
            tgb = tg;
        end else begin
            exp_p = 0;
            tg  = v ? "R6" : "R8";
            tgb = tg;
        end
        @(negedge clk);
        chk(tg, int'(delta_o), exp_d);
        chk(tgb, int'(interval_o), exp_b);
        chk("R3", int'(boundary_o), exp_p);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        int dv[5]  = '{0, 1, 3749, 7498, 7499};
        int lv[4]  = '{0, 5, 7500, 65535};
        int iv[3]  = '{0, 100, 65535};
        int cv[5]  = '{0, 1, 7499, 30000, 65535};
        int bad[4] = '{7500, 7501, 8000, 8191};

        repeat (3) @(negedge clk);
        // R9: state held at zero in reset
        chk("R9", int'(delta_o), 0);
        chk("R9", int'(interval_o), 0);
        chk("R9", int'(boundary_o), 0);
        rst_n = 1'b1;

        // R4 / R5 sweep of the reload arithmetic, idle hold (R8) between loads
        foreach (dv[a]) foreach (lv[b]) foreach (iv[c]) foreach (cv[e]) begin
            cyc(0, 1, a * 4000 + e * 2999 + 7, dv[a], cv[e], lv[b], iv[c]);
            cyc(0, 0, 0, 0, 0, 0, 0);
        end

        // R6: out-of-range packets ignored, with and without a tick
        cyc(0, 1, 300, 0, 0, 0, 7490);
        foreach (bad[k]) begin
            cyc(0, 1, 1234, bad[k], 0, 99, 99);
            cyc(1, 1, 1234, bad[k], 0, 99, 99);
        end
        // rejected packet while at the top still lets the tick roll over (R6, R2)
        cyc(0, 1, 9, 0, 0, 0, 7499);
        cyc(1, 1, 4000, 7500, 0, 0, 0);

        // R2 / R3: coarse rollover 16383 -> 0
        cyc(0, 1, 16383, 0, 0, 0, 7498);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);

        // R7: load collides with a tick at the top value
        cyc(0, 1, 20, 0, 0, 0, 7499);
        cyc(1, 1, 5, 0, 0, 0, 7499);
        cyc(1, 1, 6, 100, 200, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);

        // R1 / R2 / R3: long run with gaps in the tick pattern
        cyc(0, 1, 16380, 0, 0, 0, 0);
        for (int i = 0; i < 3 * 7500 + 40; i++) begin
            cyc((i % 5) != 0, 0, 0, 0, 0, 0, 0);
        end

        // R9: asynchronous reset mid-run
        @(negedge clk);
        #3 rst_n = 1'b0;
        #2;
        chk("R9", int'(delta_o), 0);
        chk("R9", int'(interval_o), 0);
        chk("R9", int'(boundary_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_d = 0; exp_b = 0; exp_p = 0;
        cyc(1, 0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule